// File: doc/BRIEF.md
# Pixel Colour-Conversion Functional Unit

This block sits beside a processor register file as an execution unit that turns luma/chroma pixel vectors into red, green and blue vectors. Each issue carries an opcode, a destination tag and three operand words, each holding `LANES` signed 16-bit samples. The unit registers the operands in one core cycle and passes them through a conversion pipeline. That pipeline advances at half the core rate, so each of its stages has two core cycles. One more registered cycle writes the result back, and the destination tag comes back with it. The unit has no bypass, so the latency is a fixed 10 core cycles.

A conversion yields three result vectors, but a write-back slot carries only two. Two opcodes therefore share the work. The red opcode starts a conversion and returns the red vector. The green/blue opcode must come after a red opcode. It starts no conversion of its own: it returns the green and blue vectors that the last accepted red conversion left behind. The core needs at least `RATE_DIV` cycles between accepted issues. Any issue that arrives sooner, or a green/blue issue that has no red partner, is dropped and raises an error pulse.

With `RATE_DIV` = 4, the parameter for a quarter-rate datapath, the four arithmetic steps fold into two stages of four core cycles each. The latency stays at 10 and the recovery becomes 4.

Top module: `csc_fu_wrap`

## Requirements
- R1: While `rst_ni` is low and in the first cycles after it is released, `wb_valid_o` and `err_o` are low.
- R2: A red issue (`op_i` = 0) that is accepted in cycle c raises `wb_valid_o` for exactly one cycle, in cycle c+10. In that cycle `wb_tag_o` equals the issued tag, `res_a_o` holds the red vector and `res_b_o` is zero.
- R3: Lane i takes its input from bits [16i+15:16i] of `y_i`, `cb_i` and `cr_i` as signed values, and places its output in bits [8i+7:8i]. With t = 1192·(Y−16) + 512: red = t + 1634·(Cr−128), green = t − 833·(Cr−128) − 400·(Cb−128), blue = t + 2066·(Cb−128). Each sum is shifted arithmetically right by 10 and then clamped to 0..255.
- R4: A green/blue issue (`op_i` = 1) that is accepted in cycle c writes back in cycle c+10. `res_a_o` holds the green vector and `res_b_o` the blue vector of the most recently accepted red conversion, and the operands of the green/blue issue are ignored.
- R5: An issue that comes less than 2 cycles (`RATE_DIV`) after the last accepted issue is rejected. `err_o` is high for one cycle, in the cycle after the issue, and nothing is written back. A rejection does not restart the recovery window. A rejected red issue leaves the held green/blue values as they were.
- R6: A green/blue issue is rejected with an `err_o` pulse if the last accepted issue was not a red one. This includes the case where no issue has been accepted since reset.
- R7: When issues are accepted every 2 cycles without a gap, each one produces exactly one write-back, and the write-backs come out in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue strobe |
| op_i | input | 1 | Opcode: 0 red, 1 green/blue |
| tag_i | input | TAG_W | Destination tag |
| y_i | input | LANES*16 | Luma operand lanes |
| cb_i | input | LANES*16 | Blue-difference chroma lanes |
| cr_i | input | LANES*16 | Red-difference chroma lanes |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_tag_o | output | TAG_W | Tag of the write-back |
| res_a_o | output | LANES*8 | Red, or green on a green/blue write-back |
| res_b_o | output | LANES*8 | Zero, or blue on a green/blue write-back |
| err_o | output | 1 | One-cycle pulse for a rejected issue |

## Verification
If the recovery counter or the pairing flag is wrong, `err_o` shows it one cycle after the issue concerned: the pulse is missing, or it follows a legal issue. If the token delay line is wrong, the write-back strobe lands on the wrong cycle or carries the wrong tag, and this shows ten cycles after the issue. If a stage enable or the held green/blue register is corrupted, the failure shows only in write-back data: red lanes that are wrong, or a green/blue write-back that returns values from a different conversion. The bench therefore checks the cycle, the tag and both data words of every write-back against a model. Directed sequences cover saturation, missing partners and issues that break the recovery interval.

// File: rtl/csc_fu_pkg.sv
package csc_fu_pkg;
  localparam int DP_STEPS = 4;
  localparam int IN_W     = 16;
  localparam int OUT_W    = 8;
  localparam int FRAC_W   = 10;
  localparam int ACC_W    = 32;

  localparam logic signed [ACC_W-1:0] K_Y   = 32'sd1192;
  localparam logic signed [ACC_W-1:0] K_RCR = 32'sd1634;
  localparam logic signed [ACC_W-1:0] K_GCR = 32'sd833;
  localparam logic signed [ACC_W-1:0] K_GCB = 32'sd400;
  localparam logic signed [ACC_W-1:0] K_BCB = 32'sd2066;
  localparam logic signed [ACC_W-1:0] Y_OFS = 32'sd16;
  localparam logic signed [ACC_W-1:0] C_OFS = 32'sd128;
  localparam logic signed [ACC_W-1:0] RND   = 32'sd1 <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = (32'sd1 <<< OUT_W) - 32'sd1;

  typedef enum logic {OP_RED = 1'b0, OP_GB = 1'b1} fu_op_e;

  typedef struct packed {
    logic signed [ACC_W-1:0] c0;
    logic signed [ACC_W-1:0] c1;
    logic signed [ACC_W-1:0] c2;
  } lane_t;

  function automatic logic signed [ACC_W-1:0] clamp_out(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] s;
    s = v >>> FRAC_W;
    if (s < 0) return '0;
    if (s > SAT_HI) return SAT_HI;
    return s;
  endfunction

  // one arithmetic step of the conversion; stages apply one or more in sequence
  function automatic lane_t dp_step(input int k, input lane_t v);
    lane_t o;
    o = v;
    case (k)
      0: begin
        o.c0 = $signed(v.c0) - Y_OFS;
        o.c1 = $signed(v.c1) - C_OFS;
        o.c2 = $signed(v.c2) - C_OFS;
      end
      1: o.c0 = $signed(v.c0) * K_Y + RND;
      2: begin
        o.c0 = $signed(v.c0) + K_RCR * $signed(v.c2);
        o.c1 = $signed(v.c0) - K_GCR * $signed(v.c2) - K_GCB * $signed(v.c1);
        o.c2 = $signed(v.c0) + K_BCB * $signed(v.c1);
      end
      default: begin
        o.c0 = clamp_out($signed(v.c0));
        o.c1 = clamp_out($signed(v.c1));
        o.c2 = clamp_out($signed(v.c2));
      end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/csc_fu_sched.sv
module csc_fu_sched
  import csc_fu_pkg::*;
#(
  parameter int RATE_DIV = 2,
  parameter int TAG_W    = 5,
  localparam int STAGES  = (DP_STEPS * 2) / RATE_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              op_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              cap_o,
  output logic [STAGES-1:0] ld_o,
  output logic              tok_vld_o,
  output fu_op_e            tok_op_o,
  output logic [TAG_W-1:0]  tok_tag_o,
  output logic              err_o
);
  localparam int LAT   = 2 + STAGES * RATE_DIV;
  localparam int DEPTH = LAT - 1;
  localparam int GAP_W = $clog2(RATE_DIV + 1);

  typedef struct packed {
    logic             vld;
    fu_op_e           op;
    logic [TAG_W-1:0] tag;
  } meta_t;

  meta_t [DEPTH-1:0] meta_q;
  logic [GAP_W-1:0]  gap_q;
  logic              last_red_q, err_q;
  logic              gap_ok, acc;

  assign gap_ok = gap_q >= GAP_W'(RATE_DIV);
  assign acc    = issue_i && gap_ok && (op_i == OP_RED || last_red_q);
  assign cap_o  = acc && (op_i == OP_RED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= GAP_W'(RATE_DIV);
      last_red_q <= 1'b0;
      err_q      <= 1'b0;
      meta_q     <= '0;
    end else begin
      err_q <= issue_i && !acc;
      if (acc) gap_q <= GAP_W'(1);
      else if (!gap_ok) gap_q <= GAP_W'(gap_q + 1'b1);
      if (acc) last_red_q <= (op_i == OP_RED);
      meta_q <= {meta_q[DEPTH-2:0], meta_t'{vld: acc, op: fu_op_e'(op_i), tag: tag_i}};
    end
  end

  // stage s+1 loads once its input has been held RATE_DIV core cycles
  for (genvar s = 0; s < STAGES; s++) begin : g_ld
    assign ld_o[s] = meta_q[(s+1)*RATE_DIV-1].vld && (meta_q[(s+1)*RATE_DIV-1].op == OP_RED);
  end

  assign tok_vld_o = meta_q[DEPTH-1].vld;
  assign tok_op_o  = meta_q[DEPTH-1].op;
  assign tok_tag_o = meta_q[DEPTH-1].tag;
  assign err_o     = err_q;

  // R5
  acc_recovery_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !acc);
  // R5
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(issue_i));
endmodule

// File: rtl/csc_fu_datapath.sv
module csc_fu_datapath
  import csc_fu_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int RATE_DIV = 2,
  localparam int STAGES  = (DP_STEPS * 2) / RATE_DIV,
  localparam int SPS     = DP_STEPS / STAGES,
  localparam int VEC_W   = LANES * IN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [VEC_W-1:0]  y_i,
  input  logic [VEC_W-1:0]  cb_i,
  input  logic [VEC_W-1:0]  cr_i,
  input  logic [STAGES-1:0] ld_i,
  output lane_t [LANES-1:0] rgb_o
);
  lane_t [LANES-1:0] st_q [STAGES+1];
  lane_t [LANES-1:0] nxt  [STAGES];

  always_comb begin
    lane_t v;
    for (int s = 0; s < STAGES; s++) begin
      for (int l = 0; l < LANES; l++) begin
        v = st_q[s][l];
        for (int j = 0; j < SPS; j++) v = dp_step(s * SPS + j, v);
        nxt[s][l] = v;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s <= STAGES; s++) st_q[s] <= '0;
    end else begin
      if (cap_i) begin
        for (int l = 0; l < LANES; l++) begin
          st_q[0][l].c0 <= ACC_W'($signed(y_i[IN_W*l +: IN_W]));
          st_q[0][l].c1 <= ACC_W'($signed(cb_i[IN_W*l +: IN_W]));
          st_q[0][l].c2 <= ACC_W'($signed(cr_i[IN_W*l +: IN_W]));
        end
      end
      for (int s = 0; s < STAGES; s++) if (ld_i[s]) st_q[s+1] <= nxt[s];
    end
  end

  assign rgb_o = st_q[STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_chk
    if (s == 0) begin : g_first
      // R2
      ld_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i[0] |-> $past(cap_i, RATE_DIV));
    end else begin : g_rest
      // R2
      ld_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i[s] |-> $past(ld_i[s-1], RATE_DIV));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int l = 0; l < LANES; l++) begin
        // R3
        out_range_chk: assert ($signed(rgb_o[l].c0) >= 0 && $signed(rgb_o[l].c0) <= SAT_HI &&
                               $signed(rgb_o[l].c1) >= 0 && $signed(rgb_o[l].c1) <= SAT_HI &&
                               $signed(rgb_o[l].c2) >= 0 && $signed(rgb_o[l].c2) <= SAT_HI);
      end
    end
  end
endmodule

// File: rtl/csc_fu_wb.sv
module csc_fu_wb
  import csc_fu_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int TAG_W   = 5,
  localparam int RES_W  = LANES * OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_vld_i,
  input  fu_op_e            tok_op_i,
  input  logic [TAG_W-1:0]  tok_tag_i,
  input  lane_t [LANES-1:0] rgb_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [RES_W-1:0]  res_a_o,
  output logic [RES_W-1:0]  res_b_o
);
  logic [RES_W-1:0] r_w, g_w, b_w;
  logic [RES_W-1:0] g_hold_q, b_hold_q;
  logic             hold_vld_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      r_w[OUT_W*l +: OUT_W] = rgb_i[l].c0[OUT_W-1:0];
      g_w[OUT_W*l +: OUT_W] = rgb_i[l].c1[OUT_W-1:0];
      b_w[OUT_W*l +: OUT_W] = rgb_i[l].c2[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      tag_o      <= '0;
      res_a_o    <= '0;
      res_b_o    <= '0;
      g_hold_q   <= '0;
      b_hold_q   <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      valid_o <= tok_vld_i;
      if (tok_vld_i) begin
        tag_o <= tok_tag_i;
        if (tok_op_i == OP_RED) begin
          res_a_o    <= r_w;
          res_b_o    <= '0;
          g_hold_q   <= g_w;
          b_hold_q   <= b_w;
          hold_vld_q <= 1'b1;
        end else begin
          res_a_o <= g_hold_q;
          res_b_o <= b_hold_q;
        end
      end
    end
  end

  // R6
  gb_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_vld_i && tok_op_i == OP_GB) |-> hold_vld_q);
  // R7
  wb_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/csc_fu_wrap.sv
module csc_fu_wrap
  import csc_fu_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int TAG_W    = 5,
  parameter int RATE_DIV = 2,
  localparam int VEC_W   = LANES * IN_W,
  localparam int RES_W   = LANES * OUT_W,
  localparam int STAGES  = (DP_STEPS * 2) / RATE_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             op_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [VEC_W-1:0] y_i,
  input  logic [VEC_W-1:0] cb_i,
  input  logic [VEC_W-1:0] cr_i,
  output logic             wb_valid_o,
  output logic [TAG_W-1:0] wb_tag_o,
  output logic [RES_W-1:0] res_a_o,
  output logic [RES_W-1:0] res_b_o,
  output logic             err_o
);
  logic              cap;
  logic [STAGES-1:0] ld;
  logic              tok_vld;
  fu_op_e            tok_op;
  logic [TAG_W-1:0]  tok_tag;
  lane_t [LANES-1:0] rgb;

  csc_fu_sched #(.RATE_DIV(RATE_DIV), .TAG_W(TAG_W)) u_sched (
    .clk_i, .rst_ni, .issue_i, .op_i, .tag_i,
    .cap_o(cap), .ld_o(ld), .tok_vld_o(tok_vld), .tok_op_o(tok_op),
    .tok_tag_o(tok_tag), .err_o
  );

  csc_fu_datapath #(.LANES(LANES), .RATE_DIV(RATE_DIV)) u_dp (
    .clk_i, .rst_ni, .cap_i(cap), .y_i, .cb_i, .cr_i, .ld_i(ld), .rgb_o(rgb)
  );

  csc_fu_wb #(.LANES(LANES), .TAG_W(TAG_W)) u_wb (
    .clk_i, .rst_ni, .tok_vld_i(tok_vld), .tok_op_i(tok_op), .tok_tag_i(tok_tag),
    .rgb_i(rgb), .valid_o(wb_valid_o), .tag_o(wb_tag_o), .res_a_o, .res_b_o
  );
endmodule

// File: tb/tb_csc_fu_wrap.sv
module tb_csc_fu_wrap;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int TAG_W = 5;
  localparam int LAT   = 10;

  typedef struct {
    int          tag;
    logic [31:0] a;
    logic [31:0] b;
    int          due;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_i = 1'b0;
  logic op_i = 1'b0;
  logic [TAG_W-1:0] tag_i = '0;
  logic [63:0] y_i = '0, cb_i = '0, cr_i = '0;
  logic wb_valid_o, err_o;
  logic [TAG_W-1:0] wb_tag_o;
  logic [31:0] res_a_o, res_b_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  exp_t q[$];
  int err_q[$];
  logic [31:0] hold_g = '0, hold_b = '0;

  csc_fu_wrap #(.LANES(LANES), .TAG_W(TAG_W), .RATE_DIV(2)) dut (
    .clk_i(clk), .rst_ni, .issue_i, .op_i, .tag_i, .y_i, .cb_i, .cr_i,
    .wb_valid_o, .wb_tag_o, .res_a_o, .res_b_o, .err_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int clampv(int v);
    int s = v >>> 10;
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  function automatic logic [63:0] v4(int a, int b, int c, int d);
    return {16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  task automatic send(input bit op, input int tag, input logic [63:0] y,
                      input logic [63:0] cb, input logic [63:0] cr,
                      input bit ok, input string req);
    exp_t e;
    logic [31:0] r, g, b;
    for (int l = 0; l < LANES; l++) begin
      int yy = int'($signed(y[16*l +: 16]));
      int bb = int'($signed(cb[16*l +: 16]));
      int rr = int'($signed(cr[16*l +: 16]));
      int t  = 1192 * (yy - 16) + 512;
      r[8*l +: 8] = 8'(clampv(t + 1634 * (rr - 128)));
      g[8*l +: 8] = 8'(clampv(t - 833 * (rr - 128) - 400 * (bb - 128)));
      b[8*l +: 8] = 8'(clampv(t + 2066 * (bb - 128)));
    end
    issue_i = 1'b1; op_i = op; tag_i = TAG_W'(tag);
    y_i = y; cb_i = cb; cr_i = cr;
    if (ok) begin
      e.tag = tag; e.due = cyc + LAT; e.req = req;
      if (!op) begin
        e.a = r; e.b = '0; hold_g = g; hold_b = b;
      end else begin
        e.a = hold_g; e.b = hold_b;
      end
      q.push_back(e);
    end else begin
      err_q.push_back(cyc + 1);
    end
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (wb_valid_o) begin
          if (q.size() == 0) begin
            chk(0, "R7", "unexpected write-back", 64'(wb_tag_o), 0);
          end else begin
            e = q.pop_front();
            chk(cyc == e.due, e.req, "write-back cycle", 64'(cyc), 64'(e.due));
            chk(int'(wb_tag_o) == e.tag, e.req, "tag", 64'(wb_tag_o), 64'(e.tag));
            chk(res_a_o == e.a, e.req, "res_a", 64'(res_a_o), 64'(e.a));
            chk(res_b_o == e.b, e.req, "res_b", 64'(res_b_o), 64'(e.b));
          end
        end else if (q.size() != 0 && q[0].due <= cyc) begin
          e = q.pop_front();
          chk(0, e.req, "missing write-back", 0, 64'(e.tag));
        end
        if (err_o) begin
          if (err_q.size() != 0 && err_q[0] == cyc) begin
            void'(err_q.pop_front());
            chk(1, "R5", "err pulse", 1, 1);
          end else begin
            chk(0, "R5", "spurious err", 1, 0);
          end
        end else if (err_q.size() != 0 && err_q[0] <= cyc) begin
          void'(err_q.pop_front());
          chk(0, "R6", "missing err", 0, 1);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk(!wb_valid_o && !err_o, "R1", "outputs in reset", {wb_valid_o, err_o}, 0);
    rst_ni = 1'b1;
    idle(2);
    chk(!wb_valid_o && !err_o, "R1", "outputs after reset", {wb_valid_o, err_o}, 0);

    // R6: green/blue with no red since reset
    send(1, 1, '0, '0, '0, 0, "R6");
    idle(1);
    // R2 mid grey then R4 partner
    send(0, 2, v4(128, 100, 180, 60), v4(128, 90, 150, 200), v4(128, 170, 110, 80), 1, "R2");
    idle(1);
    send(1, 3, v4(999, 999, 999, 999), '0, '0, 1, "R4");
    idle(1);
    // R3 saturation and signed inputs
    send(0, 4, v4(235, 16, -200, 3000), v4(128, 16, 128, 500), v4(240, 128, -300, 128), 1, "R3");
    idle(1);
    send(1, 5, '0, '0, '0, 1, "R3");
    idle(1);
    send(0, 6, v4(16, 235, 20, 240), v4(240, 16, 16, 240), v4(16, 240, 240, 16), 1, "R3");
    idle(1);
    send(1, 7, '0, '0, '0, 1, "R3");
    idle(1);
    // R7 sustained issue at the recovery interval
    for (int i = 0; i < 6; i++) begin
      send(i % 2, 8 + i, v4(16 + 40*i, 50 + 30*i, 200 - 10*i, 100 + i),
           v4(90 + 20*i, 128, 60 + 25*i, 16 + 40*i),
           v4(200 - 20*i, 128 + i, 30 + 35*i, 240 - 30*i), 1, "R7");
      idle(1);
    end
    // R5: rejected red between a red and its partner
    send(0, 20, v4(80, 90, 100, 110), v4(60, 70, 200, 210), v4(220, 40, 128, 30), 1, "R5");
    send(0, 21, v4(300, 300, 300, 300), v4(0, 0, 0, 0), v4(0, 0, 0, 0), 0, "R5");
    send(1, 22, '0, '0, '0, 1, "R5");
    send(1, 23, '0, '0, '0, 0, "R5");
    idle(1);
    // R6: second green/blue without a new red
    send(1, 24, '0, '0, '0, 0, "R6");
    idle(1);
    send(0, 25, v4(50, 150, 250, 16), v4(128, 60, 220, 128), v4(128, 200, 40, 128), 1, "R4");
    idle(1);
    send(1, 26, '0, '0, '0, 1, "R4");
    // drain
    idle(LAT + 4);
    chk(q.size() == 0, "R7", "pending write-backs", 64'(q.size()), 0);
    chk(err_q.size() == 0, "R5", "pending errors", 64'(err_q.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule